// File: doc/BRIEF.md
# Memory-Mapped Master Traffic Driver

This block is a synthesizable bus master that plays a stream of read and write commands onto a memory-mapped bus with a waitrequest stall signal, and measures how the slave answered each one. Commands arrive one at a time on a valid/ready port. Each command carries an operation, an address, write data, a tag, and a flag that marks the last command of a list. For every command the block waits a programmable start-up delay, then drives the command. It holds the command on the bus while the slave stalls and counts the stall cycles. After the slave accepts the command, it keeps the bus quiet for a programmable idle gap.

Responses return in issue order. Read data arrives either on a read-data-valid strobe, which allows several reads and writes to be in flight, or after a fixed read latency, in which case only one transaction is in flight at a time. Write completions arrive on a write-response strobe. Each response is reported with its tag, its stall count and its latency, counted from the acceptance cycle. Three one-cycle event strobes mark command issue, response completion, and completion of the whole list.

Top module: `mm_traffic_master`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `avRead`, `avWrite`, `evCmdIssued`, `evRspDone` and `evAllDone` are low. `avRead` and `avWrite` are never high together.
- R2: If a command is taken on the command port in cycle c, the bus command (`avRead` for cmdWrite=0, `avWrite` for cmdWrite=1) is first driven in cycle c+1+`cfgInitDelay`.
- R3: While a command is on the bus and `avWaitReq` is high, the next cycle shows the same operation, `avAddr` and `avWdata`. The command is accepted in the first cycle in which it is driven and `avWaitReq` is low.
- R4: `rspWait` reports the number of cycles in which `avWaitReq` was high while that transaction was on the bus.
- R5: After acceptance in cycle k, the bus stays idle and `cmdReady` stays low through cycle k+`cfgIdleGap`. `cmdReady` is high from cycle k+1+`cfgIdleGap`, unless R7 or R12 holds it low. `cmdReady` is never high while a command is on the bus.
- R6: With `cfgUseValid`=1, a read answered by `avRdValid` in cycle j, after acceptance in cycle k, is reported in cycle j+1 with `evRspDone`=1, `rspData` equal to `avRdata` of cycle j, and `rspLatency`=j-k.
- R7: With `cfgUseValid`=0, read data is captured from `avRdata` in cycle k+FIXED_LAT and reported in the next cycle with `rspLatency`=FIXED_LAT. `avRdValid` has no effect, and `cmdReady` stays low while any transaction is still awaiting its response.
- R8: A write whose `avWrRespValid` arrives in cycle j, after acceptance in cycle k, is reported in cycle j+1 with `rspIsWrite`=1 and `rspLatency`=j-k.
- R9: `evCmdIssued` is high for exactly one cycle per transaction: the first cycle in which that command is driven.
- R10: Responses are reported in issue order, each carrying the `cmdTag` of its own command.
- R11: `evAllDone` pulses once, in the same cycle as the `evRspDone` of the command that had `cmdLast`=1.
- R12: With `cfgUseValid`=1, `cmdReady` is low while DEPTH transactions are awaiting responses, so the tracking queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgUseValid | input | 1 | 1: reads end on avRdValid; 0: fixed read latency |
| cfgInitDelay | input | CNT_W | Cycles between taking a command and driving it |
| cfgIdleGap | input | CNT_W | Idle cycles after each acceptance |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command taken when both are high |
| cmdWrite | input | 1 | 1 write, 0 read |
| cmdAddr | input | ADDR_W | Command address |
| cmdWdata | input | DATA_W | Write data |
| cmdTag | input | TAG_W | Transaction tag |
| cmdLast | input | 1 | Marks the final command of a list |
| avAddr | output | ADDR_W | Bus address |
| avRead | output | 1 | Bus read request |
| avWrite | output | 1 | Bus write request |
| avWdata | output | DATA_W | Bus write data |
| avWaitReq | input | 1 | Slave stall |
| avRdata | input | DATA_W | Read data |
| avRdValid | input | 1 | Read data valid |
| avWrRespValid | input | 1 | Write response |
| rspTag | output | TAG_W | Tag of reported response |
| rspIsWrite | output | 1 | Reported response is a write |
| rspData | output | DATA_W | Read data of reported response |
| rspWait | output | CNT_W | Stall cycles of reported transaction |
| rspLatency | output | CNT_W | Acceptance-to-response cycles |
| evCmdIssued | output | 1 | Command-issued strobe |
| evRspDone | output | 1 | Response-complete strobe, qualifies rsp* |
| evAllDone | output | 1 | All-transactions-complete strobe |

## Verification
A corrupted state register or delay counter shows up in the same cycle as a wrong `avRead`/`avWrite` or `cmdReady` value, because the bench predicts both exactly for every cycle. A wrong tracking-queue pointer or count shows up at the next `evRspDone` as a wrong tag, stall count or latency. It can also show up as `cmdReady` at the wrong point in a long-latency run that fills the queue. A stale timestamp gives a latency mismatch on the first response after it. In fixed-latency mode, a wrong capture cycle gives wrong read data one cycle after the expected capture.

// File: rtl/mm_traffic_pkg.sv
package mm_traffic_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_INIT  = 2'd1,
    ST_BUS   = 2'd2,
    ST_GAP   = 2'd3
  } ctrl_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // command taken from the command port
    logic enterBus;  // command goes onto the bus next cycle
    logic onBus;     // command currently driven
    logic accept;    // slave accepts this cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/mm_traffic_ctrl.sv
module mm_traffic_ctrl
  import mm_traffic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgUseValid,
  input  logic [CNT_W-1:0] cfgInitDelay,
  input  logic [CNT_W-1:0] cfgIdleGap,
  input  logic             cmdValid,
  input  logic             avWaitReq,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output logic             cmdReady,
  output ctrl_strobe_t     str
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ctrl_state_e      state;
  logic [CNT_W-1:0] dly;
  logic             canTake;

  // fixed-latency mode keeps a single transaction in flight
  assign canTake  = !fifoFull && (cfgUseValid || fifoEmpty);
  assign cmdReady = (state == ST_READY) && canTake;

  always_comb begin
    str          = '0;
    str.load     = cmdValid && cmdReady;
    str.onBus    = (state == ST_BUS);
    str.accept   = str.onBus && !avWaitReq;
    str.enterBus = (str.load && (cfgInitDelay == '0)) ||
                   ((state == ST_INIT) && (dly == ONE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_READY;
      dly   <= '0;
    end else begin
      unique case (state)
        ST_READY: if (str.load) begin
          if (cfgInitDelay == '0) state <= ST_BUS;
          else begin
            state <= ST_INIT;
            dly   <= cfgInitDelay;
          end
        end
        ST_INIT: begin
          if (dly == ONE) state <= ST_BUS;
          dly <= dly - ONE;
        end
        ST_BUS: if (str.accept) begin
          if (cfgIdleGap == '0) state <= ST_READY;
          else begin
            state <= ST_GAP;
            dly   <= cfgIdleGap;
          end
        end
        ST_GAP: begin
          if (dly == ONE) state <= ST_READY;
          dly <= dly - ONE;
        end
        default: state <= ST_READY;
      endcase
    end
  end

endmodule

// File: rtl/mm_traffic_dp.sv
module mm_traffic_dp
  import mm_traffic_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 16,
  parameter int DEPTH     = 4,
  parameter int FIXED_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      str,
  input  logic              cfgUseValid,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              cmdLast,
  input  logic              avWaitReq,
  input  logic [DATA_W-1:0] avRdata,
  input  logic              avRdValid,
  input  logic              avWrRespValid,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic [ADDR_W-1:0] avAddr,
  output logic              avRead,
  output logic              avWrite,
  output logic [DATA_W-1:0] avWdata,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspIsWrite,
  output logic [DATA_W-1:0] rspData,
  output logic [CNT_W-1:0]  rspWait,
  output logic [CNT_W-1:0]  rspLatency,
  output logic              evCmdIssued,
  output logic              evRspDone,
  output logic              evAllDone
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int ENT_W  = TAG_W + 2 + 2 * CNT_W;
  localparam int LAST_B = 2 * CNT_W;
  localparam int WR_B   = LAST_B + 1;
  localparam logic [CNT_W-1:0] FIX_L = CNT_W'(FIXED_LAT);

  // held command
  logic              cmdWriteQ, cmdLastQ;
  logic [ADDR_W-1:0] cmdAddrQ;
  logic [DATA_W-1:0] cmdWdataQ;
  logic [TAG_W-1:0]  cmdTagQ;
  logic [CNT_W-1:0]  now, waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWriteQ <= 1'b0; cmdLastQ <= 1'b0; cmdAddrQ <= '0;
      cmdWdataQ <= '0;   cmdTagQ  <= '0;
    end else if (str.load) begin
      cmdWriteQ <= cmdWrite; cmdLastQ <= cmdLast; cmdAddrQ <= cmdAddr;
      cmdWdataQ <= cmdWdata; cmdTagQ  <= cmdTag;
    end
  end

  assign avAddr  = cmdAddrQ;
  assign avWdata = cmdWdataQ;
  assign avRead  = str.onBus && !cmdWriteQ;
  assign avWrite = str.onBus && cmdWriteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      now         <= '0;
      waitCnt     <= '0;
      evCmdIssued <= 1'b0;
    end else begin
      now         <= now + CNT_W'(1);
      evCmdIssued <= str.enterBus;
      if (str.enterBus)                waitCnt <= '0;
      else if (str.onBus && avWaitReq) waitCnt <= waitCnt + CNT_W'(1);
    end
  end

  // in-order tracking queue: {tag, isWrite, isLast, stamp, wait}
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [OCC_W-1:0] occ;
  logic [DEPTH-1:0][ENT_W-1:0] slots;
  logic [ENT_W-1:0] newEnt, head;
  logic             push, pop;

  assign newEnt = {cmdTagQ, cmdWriteQ, cmdLastQ, now, waitCnt};
  assign push   = str.accept;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENT_W-1:0] ent;
    always_ff @(posedge clk) begin
      if (push && (wrPtr == PTR_W'(i))) ent <= newEnt;
    end
    assign slots[i] = ent;
  end

  assign head      = slots[rdPtr];
  assign fifoEmpty = (occ == '0);
  assign fifoFull  = (occ == OCC_W'(DEPTH));

  logic             headWr, headLast;
  logic [CNT_W-1:0] headStamp, headWait, headAge;
  assign headWr    = head[WR_B];
  assign headLast  = head[LAST_B];
  assign headStamp = head[2*CNT_W-1:CNT_W];
  assign headWait  = head[CNT_W-1:0];
  assign headAge   = now - headStamp;

  always_comb begin
    if (fifoEmpty)        pop = 1'b0;
    else if (headWr)      pop = avWrRespValid;
    else if (cfgUseValid) pop = avRdValid;
    else                  pop = (headAge == FIX_L);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  // registered response report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evRspDone  <= 1'b0;
      evAllDone  <= 1'b0;
      rspTag     <= '0;
      rspIsWrite <= 1'b0;
      rspData    <= '0;
      rspWait    <= '0;
      rspLatency <= '0;
    end else begin
      evRspDone <= pop;
      evAllDone <= pop && headLast;
      if (pop) begin
        rspTag     <= head[ENT_W-1:WR_B+1];
        rspIsWrite <= headWr;
        rspData    <= headWr ? '0 : avRdata;
        rspWait    <= headWait;
        rspLatency <= headAge;
      end
    end
  end

endmodule

// File: rtl/mm_traffic_master.sv
module mm_traffic_master
  import mm_traffic_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int CNT_W     = 16,
  parameter int DEPTH     = 4,
  parameter int FIXED_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgUseValid,
  input  logic [CNT_W-1:0]  cfgInitDelay,
  input  logic [CNT_W-1:0]  cfgIdleGap,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic              cmdLast,
  output logic [ADDR_W-1:0] avAddr,
  output logic              avRead,
  output logic              avWrite,
  output logic [DATA_W-1:0] avWdata,
  input  logic              avWaitReq,
  input  logic [DATA_W-1:0] avRdata,
  input  logic              avRdValid,
  input  logic              avWrRespValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspIsWrite,
  output logic [DATA_W-1:0] rspData,
  output logic [CNT_W-1:0]  rspWait,
  output logic [CNT_W-1:0]  rspLatency,
  output logic              evCmdIssued,
  output logic              evRspDone,
  output logic              evAllDone
);

  ctrl_strobe_t str;
  logic         fifoFull, fifoEmpty;

  mm_traffic_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgUseValid(cfgUseValid),
    .cfgInitDelay(cfgInitDelay), .cfgIdleGap(cfgIdleGap),
    .cmdValid(cmdValid), .avWaitReq(avWaitReq),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .cmdReady(cmdReady), .str(str)
  );

  mm_traffic_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .CNT_W(CNT_W), .DEPTH(DEPTH), .FIXED_LAT(FIXED_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .cfgUseValid(cfgUseValid),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdTag(cmdTag), .cmdLast(cmdLast),
    .avWaitReq(avWaitReq), .avRdata(avRdata), .avRdValid(avRdValid),
    .avWrRespValid(avWrRespValid),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .avAddr(avAddr), .avRead(avRead), .avWrite(avWrite), .avWdata(avWdata),
    .rspTag(rspTag), .rspIsWrite(rspIsWrite), .rspData(rspData),
    .rspWait(rspWait), .rspLatency(rspLatency),
    .evCmdIssued(evCmdIssued), .evRspDone(evRspDone), .evAllDone(evAllDone)
  );

endmodule

// File: rtl/mm_traffic_checker.sv
module mm_traffic_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              avRead,
  input logic              avWrite,
  input logic [ADDR_W-1:0] avAddr,
  input logic [DATA_W-1:0] avWdata,
  input logic              avWaitReq,
  input logic              evCmdIssued,
  input logic              evRspDone,
  input logic              evAllDone
);

  // R1: never read and write together
  p_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({avRead, avWrite}));

  // R3: a stalled command is held unchanged
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (avRead || avWrite) && avWaitReq |=>
      $stable(avRead) && $stable(avWrite) && $stable(avAddr) && $stable(avWdata)
      && (avRead || avWrite));

  // R5: no new command taken while the bus is busy
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !avRead && !avWrite);

  // R9: issue strobe marks the first driven cycle
  p_issue_edge_r9: assert property (@(posedge clk) disable iff (!rstN)
    evCmdIssued |-> (avRead || avWrite) && !$past(avRead || avWrite));

  // R9: issue strobe lasts one cycle
  p_issue_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    evCmdIssued |=> !evCmdIssued);

  // R11: all-done coincides with a response
  p_alldone_rsp_r11: assert property (@(posedge clk) disable iff (!rstN)
    evAllDone |-> evRspDone);

endmodule

bind mm_traffic_master mm_traffic_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .avRead(avRead), .avWrite(avWrite),
  .avAddr(avAddr), .avWdata(avWdata), .avWaitReq(avWaitReq),
  .evCmdIssued(evCmdIssued), .evRspDone(evRspDone), .evAllDone(evAllDone)
);

// File: tb/sim_mm_traffic_master.sv
`timescale 1ns/1ps
module sim_mm_traffic_master;

  localparam int ADDR_W = 16, DATA_W = 32, TAG_W = 4, CNT_W = 16;
  localparam int DEPTH = 4, FIX = 3;
  localparam int QN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgUseValid = 1'b1;
  logic [CNT_W-1:0] cfgInitDelay = '0, cfgIdleGap = '0;
  logic cmdValid = 1'b0, cmdWrite = 1'b0, cmdLast = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdWdata = '0;
  logic [TAG_W-1:0] cmdTag = '0;
  logic avWaitReq = 1'b0, avRdValid = 1'b0, avWrRespValid = 1'b0;
  logic [DATA_W-1:0] avRdata = '0;
  logic cmdReady, avRead, avWrite, rspIsWrite, evCmdIssued, evRspDone, evAllDone;
  logic [ADDR_W-1:0] avAddr;
  logic [DATA_W-1:0] avWdata, rspData;
  logic [TAG_W-1:0] rspTag;
  logic [CNT_W-1:0] rspWait, rspLatency;

  always #5 clk = ~clk;

  mm_traffic_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W),
                      .DEPTH(DEPTH), .FIXED_LAT(FIX)) u0 (
    .clk(clk), .rstN(rstN), .cfgUseValid(cfgUseValid), .cfgInitDelay(cfgInitDelay),
    .cfgIdleGap(cfgIdleGap), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdTag(cmdTag),
    .cmdLast(cmdLast), .avAddr(avAddr), .avRead(avRead), .avWrite(avWrite),
    .avWdata(avWdata), .avWaitReq(avWaitReq), .avRdata(avRdata),
    .avRdValid(avRdValid), .avWrRespValid(avWrRespValid), .rspTag(rspTag),
    .rspIsWrite(rspIsWrite), .rspData(rspData), .rspWait(rspWait),
    .rspLatency(rspLatency), .evCmdIssued(evCmdIssued), .evRspDone(evRspDone),
    .evAllDone(evAllDone)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] dataFn(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  // scoreboard of accepted transactions
  logic [TAG_W-1:0]  qTag [QN];
  logic              qWr [QN], qLast [QN];
  logic [ADDR_W-1:0] qAddr [QN];
  int                qK [QN], qStall [QN], qResp [QN];

  task automatic runPhase(input bit useV, input int d, input int gap, input int n,
                          input int latLo, input int latSpan);
    int t, hIdx, accIdx, slvIdx, chkIdx, allCnt, issueAt, readyFrom, lastResp;
    int stallN, stallCnt, outst, tail;
    bit inflight, busExp, expRsp, expReady;
    logic curWr, curLast;
    logic [ADDR_W-1:0] curAddr;
    logic [DATA_W-1:0] curData;
    logic [TAG_W-1:0] curTag;
    string lt;
    hIdx = 0; accIdx = 0; slvIdx = 0; chkIdx = 0; allCnt = 0; issueAt = 0;
    readyFrom = 0; lastResp = -1; stallN = 0; stallCnt = 0; inflight = 0; tail = 0;
    curWr = 0; curLast = 0; curAddr = '0; curData = '0; curTag = '0;
    @(negedge clk);
    rstN = 1'b0;
    cfgUseValid = useV; cfgInitDelay = CNT_W'(d); cfgIdleGap = CNT_W'(gap);
    cmdValid = 0; avRdValid = 0; avWrRespValid = 0; avWaitReq = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!avRead && !avWrite && !evCmdIssued && !evRspDone && !evAllDone,
          "R1 outputs in reset", {avRead, avWrite, evCmdIssued, evRspDone, evAllDone}, 0);
    end
    rstN = 1'b1;
    t = 0;
    while (t < 4000) begin
      if (t == 0)
        chk(!avRead && !avWrite && !evCmdIssued && !evRspDone && !evAllDone,
            "R1 first cycle after reset", {avRead, avWrite, evRspDone}, 0);
      // responses reported one cycle after the slave answers
      expRsp = (chkIdx < slvIdx) && (qResp[chkIdx] == t - 1);
      chk(evRspDone == expRsp, "R10 response strobe", evRspDone, expRsp);
      if (expRsp && evRspDone) begin
        lt = qWr[chkIdx] ? "R8" : (useV ? "R6" : "R7");
        chk(rspTag == qTag[chkIdx], "R10 tag", rspTag, qTag[chkIdx]);
        chk(rspIsWrite == qWr[chkIdx], {lt, " kind"}, rspIsWrite, qWr[chkIdx]);
        chk(rspLatency == CNT_W'(qResp[chkIdx] - qK[chkIdx]), {lt, " latency"},
            rspLatency, qResp[chkIdx] - qK[chkIdx]);
        chk(rspWait == CNT_W'(qStall[chkIdx]), "R4 wait count", rspWait, qStall[chkIdx]);
        if (!qWr[chkIdx])
          chk(rspData == dataFn(qAddr[chkIdx]), {lt, " read data"}, rspData, dataFn(qAddr[chkIdx]));
        chk(evAllDone == qLast[chkIdx], "R11 all-done placement", evAllDone, qLast[chkIdx]);
        chkIdx++;
      end
      if (evAllDone) allCnt++;
      // command-port readiness
      outst = accIdx - slvIdx;
      expReady = (t >= readyFrom) && (useV ? (outst < DEPTH) : (outst == 0));
      chk(cmdReady == expReady, !useV ? "R7 ready" : (outst >= DEPTH ? "R12 ready" : "R5 ready"),
          cmdReady, expReady);
      // bus activity
      busExp = inflight && (t >= issueAt);
      chk(avRead == (busExp && !curWr), "R2 read timing", avRead, busExp && !curWr);
      chk(avWrite == (busExp && curWr), "R2 write timing", avWrite, busExp && curWr);
      chk(evCmdIssued == (inflight && t == issueAt), "R9 issue strobe", evCmdIssued,
          inflight && t == issueAt);
      if (busExp) begin
        chk(avAddr == curAddr, "R3 address held", avAddr, curAddr);
        if (curWr) chk(avWdata == curData, "R3 data held", avWdata, curData);
      end
      // command offer
      cmdValid = (hIdx < n) && ($urandom % 4 != 0);
      cmdWrite = $urandom % 2;
      cmdAddr  = ADDR_W'($urandom);
      cmdWdata = $urandom;
      cmdTag   = TAG_W'($urandom);
      cmdLast  = (hIdx == n - 1);
      if (cmdValid && cmdReady) begin
        inflight = 1; curWr = cmdWrite; curAddr = cmdAddr; curData = cmdWdata;
        curTag = cmdTag; curLast = cmdLast;
        issueAt = t + 1 + d; readyFrom = 1 << 30; hIdx++;
      end
      // slave: stalls
      if (avRead || avWrite) begin
        if (evCmdIssued) begin stallN = $urandom % 4; stallCnt = 0; end
        avWaitReq = (stallCnt < stallN);
        if (avWaitReq) stallCnt++;
        else begin
          qTag[accIdx] = curTag; qWr[accIdx] = curWr; qLast[accIdx] = curLast;
          qAddr[accIdx] = curAddr; qK[accIdx] = t; qStall[accIdx] = stallN;
          if (!useV && !curWr) qResp[accIdx] = t + FIX;
          else begin
            qResp[accIdx] = t + latLo + int'($urandom % latSpan);
            if (qResp[accIdx] <= lastResp) qResp[accIdx] = lastResp + 1;
          end
          lastResp = qResp[accIdx];
          accIdx++; inflight = 0; readyFrom = t + 1 + gap;
        end
      end else avWaitReq = $urandom % 2;   // ignored when idle
      // slave: responses
      avRdValid = 0; avWrRespValid = 0; avRdata = $urandom;
      if (slvIdx < accIdx && qResp[slvIdx] == t) begin
        if (qWr[slvIdx]) avWrRespValid = 1;
        else begin
          avRdata = dataFn(qAddr[slvIdx]);
          if (useV) avRdValid = 1;
        end
        slvIdx++;
      end
      if (!useV && !avRdValid) avRdValid = $urandom % 2;  // R7 noise
      if (chkIdx == n) begin
        tail++;
        if (tail > 3) break;
      end
      @(negedge clk);
      t++;
    end
    chk(chkIdx == n, "R11 every response seen", chkIdx, n);
    chk(allCnt == 1, "R11 single all-done", allCnt, 1);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    runPhase(1, 2, 1, 20, 1, 4);
    runPhase(1, 0, 0, 24, 6, 7);   // long latency: fills tracking queue
    runPhase(0, 2, 1, 12, 1, 5);   // fixed read latency
    runPhase(0, 0, 0, 10, 1, 3);
    runPhase(1, 3, 2, 8, 1, 2);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule